// File: doc/BRIEF.md
# Wait-State Byte-Wide Memory Bus Controller

This block connects a fast synchronous core to a slow asynchronous byte-wide non-volatile memory. The core presents one request at a time: an address, a read/write flag and write data. The controller then drives an 18-bit address bus, active-low read and write strobes, and four attribute lines. It holds the strobe asserted for a programmable number of core clock cycles, so that the memory's access time fits inside the strobe window. For reads it captures the byte on the final strobe cycle. For every access it reports completion with a single-cycle done pulse.

The strobe length is the wait-state setting, one core clock per wait state. The setting is sampled when a request is accepted, so each access may use a different value. For example, 12 wait states at an 80 MHz core clock give a 150 ns window. Each of the four attribute lines is programmed on its own. In chip-select mode the line is an active-low select that compares a 3-bit field of the address with a per-line base value. In address mode the line carries one of four extra high address bits. The address and any attribute lines in address mode keep their last value between accesses. The write data reaches the pad as a value plus an output enable, and the enable is high only while the write strobe is asserted.

Top module: `ext_mem_ctrl`

## Requirements
- R1: After reset, `req_ready_o`=1, both strobes are high, `rsp_done_o`=0, `mem_addr_o`=0, `mem_attr_o`=4'hF and `mem_wdata_oe_o`=0.
- R2: A read holds `mem_rd_n_o` low for exactly N consecutive cycles, where N is the accepted wait setting. `mem_wr_n_o` stays high during a read, and the two strobes are never low together.
- R3: A write holds `mem_wr_n_o` low for N cycles with `mem_rd_n_o` high. `mem_wdata_oe_o` is 1 exactly while `mem_wr_n_o` is low, and during that time `mem_wdata_o` equals the accepted write byte.
- R4: `rsp_done_o` is high for exactly one cycle: the first cycle after the strobe releases. For a read, `rsp_rdata_o` then equals the byte the memory presented during the last strobe cycle, and it keeps that value afterwards.
- R5: A wait setting of 0 is treated as 1, giving a one-cycle strobe.
- R6: `mem_addr_o` equals bits 17:0 of the accepted request address from the first strobe cycle onward. It does not change until the next request is accepted.
- R7: `req_ready_o` is 1 only when the controller is idle. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. Request inputs present while the controller is busy have no effect on the access in progress.
- R8: An attribute line k whose bit in `cfg_attr_cs_i` is 0 at acceptance outputs request address bit 18+k. It holds that value until the next acceptance.
- R9: An attribute line k whose bit in `cfg_attr_cs_i` is 1 at acceptance is low only during strobe cycles. It goes low only when request address bits 17:15 equal `cfg_cs_base_i[3k+2:3k]`. It is high at all other times.
- R10: Changes to `cfg_wait_i`, `cfg_attr_cs_i` or `cfg_cs_base_i` after acceptance do not alter the access in progress.
- R11: Every wait setting from 0 to 20 gives its own strobe length of max(setting,1) cycles, with the setting taken per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wait_i | input | 5 | Wait-state count from the bus control register |
| cfg_attr_cs_i | input | 4 | Per attribute line: 1 = chip select, 0 = high address bit |
| cfg_cs_base_i | input | 12 | Per-line 3-bit compare base, line k at bits 3k+2:3k |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Request address; bits 21:18 feed attribute lines in address mode |
| req_wdata_i | input | 8 | Write byte |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Captured read byte |
| mem_addr_o | output | 18 | Memory address bus |
| mem_rd_n_o | output | 1 | Read strobe, active low |
| mem_wr_n_o | output | 1 | Write strobe, active low |
| mem_attr_o | output | 4 | Attribute lines (chip selects or extra address) |
| mem_rdata_i | input | 8 | Data from memory |
| mem_wdata_o | output | 8 | Data to memory |
| mem_wdata_oe_o | output | 1 | Pad output enable for write data |

## Verification
A wait counter loaded with a wrong value, or one that decrements wrongly, shows up as a strobe one or more cycles longer or shorter than the setting. It is visible at the strobe pins within the same access, and the sweep covers every setting up to 20. A stuck or mis-sequenced state shows as a missing or doubled done pulse, or as a ready that never returns. It can also show as a read byte taken outside the last strobe cycle, which the address-dependent memory model turns into a wrong `rsp_rdata_o` in the done cycle. Compare or latch errors on the attribute lines appear as a wrong level on a select or a high address bit. They are visible during the very next strobe cycle or the first idle cycle after it.

// File: rtl/ext_mem_pkg.sv
package ext_mem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_DONE   = 2'd2
  } bus_state_e;
endpackage

// File: rtl/ext_mem_wait_cnt.sv
module ext_mem_wait_cnt #(
  parameter int unsigned WS_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WS_W-1:0] wait_i,
  input  logic            run_i,
  output logic            last_o
);
  logic [WS_W-1:0] cnt_q;

  // remaining strobe cycles after the current one; zero setting clamps to one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (wait_i == '0) ? '0 : wait_i - WS_W'(1);
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - WS_W'(1);
    end
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/ext_mem_attr_lines.sv
module ext_mem_attr_lines #(
  parameter int unsigned NUM_ATTR = 4,
  parameter int unsigned CMP_W    = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      active_i,
  input  logic [NUM_ATTR-1:0]       mode_i,
  input  logic [NUM_ATTR*CMP_W-1:0] base_i,
  input  logic [CMP_W-1:0]          cmp_i,
  input  logic [NUM_ATTR-1:0]       hi_i,
  output logic [NUM_ATTR-1:0]       attr_o,
  output logic [NUM_ATTR-1:0]       mode_q_o
);
  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_line
    logic cs_mode_q;
    logic hit_q;
    logic hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cs_mode_q <= 1'b1;
        hit_q     <= 1'b0;
        hi_q      <= 1'b0;
      end else if (load_i) begin
        cs_mode_q <= mode_i[g];
        hit_q     <= (cmp_i == base_i[g*CMP_W +: CMP_W]);
        hi_q      <= hi_i[g];
      end
    end

    assign attr_o[g]   = cs_mode_q ? ~(hit_q & active_i) : hi_q;
    assign mode_q_o[g] = cs_mode_q;
  end
endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import ext_mem_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WS_W     = 5,
  parameter int unsigned NUM_ATTR = 4,
  parameter int unsigned CMP_W    = 3,
  localparam int unsigned REQ_AW  = ADDR_W + NUM_ATTR
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [WS_W-1:0]           cfg_wait_i,
  input  logic [NUM_ATTR-1:0]       cfg_attr_cs_i,
  input  logic [NUM_ATTR*CMP_W-1:0] cfg_cs_base_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_write_i,
  input  logic [REQ_AW-1:0]         req_addr_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic                      rsp_done_o,
  output logic [DATA_W-1:0]         rsp_rdata_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic                      mem_rd_n_o,
  output logic                      mem_wr_n_o,
  output logic [NUM_ATTR-1:0]       mem_attr_o,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic [DATA_W-1:0]         mem_wdata_o,
  output logic                      mem_wdata_oe_o
);
  bus_state_e          state_q;
  logic                accept;
  logic                last;
  logic                strobe;
  logic                we_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdata_q;
  logic [NUM_ATTR-1:0] attr_mode_q;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign strobe = (state_q == ST_STROBE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (accept) state_q <= ST_STROBE;
        ST_STROBE: if (last)   state_q <= ST_DONE;
        default:               state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= req_write_i;
      addr_q  <= req_addr_i[ADDR_W-1:0];
      wdata_q <= req_wdata_i;
    end
  end

  // capture on the final strobe cycle, while the memory still drives the bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (strobe && last && !we_q) begin
      rdata_q <= mem_rdata_i;
    end
  end

  ext_mem_wait_cnt #(.WS_W(WS_W)) i_wait_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .wait_i (cfg_wait_i),
    .run_i  (strobe),
    .last_o (last)
  );

  ext_mem_attr_lines #(.NUM_ATTR(NUM_ATTR), .CMP_W(CMP_W)) i_attr_lines (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .active_i (strobe),
    .mode_i   (cfg_attr_cs_i),
    .base_i   (cfg_cs_base_i),
    .cmp_i    (req_addr_i[ADDR_W-1 -: CMP_W]),
    .hi_i     (req_addr_i[REQ_AW-1 -: NUM_ATTR]),
    .attr_o   (mem_attr_o),
    .mode_q_o (attr_mode_q)
  );

  assign req_ready_o    = (state_q == ST_IDLE);
  assign rsp_done_o     = (state_q == ST_DONE);
  assign rsp_rdata_o    = rdata_q;
  assign mem_addr_o     = addr_q;
  assign mem_rd_n_o     = ~(strobe & ~we_q);
  assign mem_wr_n_o     = ~(strobe & we_q);
  assign mem_wdata_o    = wdata_q;
  assign mem_wdata_oe_o = strobe & we_q;
endmodule

// File: rtl/ext_mem_ctrl_chk.sv
module ext_mem_ctrl_chk #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned NUM_ATTR = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic                rsp_done_o,
  input logic                mem_rd_n_o,
  input logic                mem_wr_n_o,
  input logic                mem_wdata_oe_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [NUM_ATTR-1:0] mem_attr_o,
  input logic [NUM_ATTR-1:0] mode_q_i
);
  logic strobe_low;
  assign strobe_low = !mem_rd_n_o || !mem_wr_n_o;

  assert_excl_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_rd_n_o && !mem_wr_n_o));

  assert_oe_follows_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wdata_oe_o == !mem_wr_n_o);

  assert_done_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> $past(strobe_low) && !strobe_low);

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  assert_addr_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_low |-> $stable(mem_addr_o));

  assert_addr_hold_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_low && $past(strobe_low)) |-> $stable(mem_addr_o));

  assert_busy_after_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  for (genvar k = 0; k < NUM_ATTR; k++) begin : g_cs
    assert_cs_idle_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!strobe_low && mode_q_i[k]) |-> mem_attr_o[k]);
  end
endmodule

bind ext_mem_ctrl ext_mem_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_ATTR (NUM_ATTR)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .rsp_done_o     (rsp_done_o),
  .mem_rd_n_o     (mem_rd_n_o),
  .mem_wr_n_o     (mem_wr_n_o),
  .mem_wdata_oe_o (mem_wdata_oe_o),
  .mem_addr_o     (mem_addr_o),
  .mem_attr_o     (mem_attr_o),
  .mode_q_i       (attr_mode_q)
);

// File: tb/test_ext_mem_ctrl.sv
module test_ext_mem_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_wait = '0;
  logic [3:0]  cfg_attr = '0;
  logic [11:0] cfg_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_rd_n, mem_wr_n;
  logic [3:0]  mem_attr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_rd_n ? 8'h00 : mem_byte(mem_addr);

  function automatic logic [3:0] exp_attr(input logic [21:0] a, input logic [3:0] mode,
                                          input logic [11:0] base, input bit active);
    logic [3:0] r;
    for (int k = 0; k < 4; k++)
      r[k] = mode[k] ? !(active && a[17:15] == base[k*3 +: 3]) : a[18+k];
    return r;
  endfunction

  ext_mem_ctrl i_ext_mem_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_wait_i(cfg_wait), .cfg_attr_cs_i(cfg_attr), .cfg_cs_base_i(cfg_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_rd_n_o(mem_rd_n), .mem_wr_n_o(mem_wr_n),
    .mem_attr_o(mem_attr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_wdata_oe_o(mem_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_access(input bit wr, input logic [21:0] a, input logic [7:0] d,
                            input int ws, input logic [3:0] mode, input logic [11:0] base);
    int n_exp = (ws == 0) ? 1 : ws;
    int n = 0;
    @(negedge clk);
    cfg_wait = 5'(ws); cfg_attr = mode; cfg_base = base;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R7 ready when idle", 32'(req_ready), 1);
    @(negedge clk);
    // busy: disturb every request and config input (R7, R10)
    cfg_wait = 5'(~ws); cfg_attr = ~mode; cfg_base = ~base;
    req_write = !wr; req_addr = ~a; req_wdata = ~d;
    chk(req_ready == 1'b0, "R7 busy after accept", 32'(req_ready), 0);
    while ((!mem_rd_n || !mem_wr_n) && n < 64) begin
      n++;
      chk(mem_addr == a[17:0], "R6 address during strobe", 32'(mem_addr), 32'(a[17:0]));
      chk(mem_attr == exp_attr(a, mode, base, 1'b1), "R8/R9 attr during strobe",
          32'(mem_attr), 32'(exp_attr(a, mode, base, 1'b1)));
      if (wr) begin
        chk(!mem_wr_n && mem_rd_n, "R3 write strobe", {30'd0, mem_rd_n, mem_wr_n}, 32'h2);
        chk(mem_oe && mem_wdata == d, "R3 write data driven", {23'd0, mem_oe, mem_wdata}, {23'd1, d});
      end else begin
        chk(!mem_rd_n && mem_wr_n, "R2 read strobe", {30'd0, mem_rd_n, mem_wr_n}, 32'h1);
        chk(!mem_oe, "R3 no drive on read", 32'(mem_oe), 0);
      end
      chk(!rsp_done, "R4 no done in strobe", 32'(rsp_done), 0);
      @(negedge clk);
    end
    if (ws == 0) chk(n == n_exp, "R5 zero wait length", 32'(n), 32'(n_exp));
    else         chk(n == n_exp, "R2/R10/R11 strobe length", 32'(n), 32'(n_exp));
    chk(rsp_done == 1'b1, "R4 done pulse", 32'(rsp_done), 1);
    chk(!mem_oe, "R3 oe off after strobe", 32'(mem_oe), 0);
    if (!wr) chk(rsp_rdata == mem_byte(a[17:0]), "R4 read data", 32'(rsp_rdata), 32'(mem_byte(a[17:0])));
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_done, "R4 done single cycle", 32'(rsp_done), 0);
    chk(req_ready, "R7 ready returns", 32'(req_ready), 1);
    chk(mem_addr == a[17:0], "R6 address held", 32'(mem_addr), 32'(a[17:0]));
    chk(mem_attr == exp_attr(a, mode, base, 1'b0), "R8/R9 attr idle",
        32'(mem_attr), 32'(exp_attr(a, mode, base, 1'b0)));
    if (!wr) chk(rsp_rdata == mem_byte(a[17:0]), "R4 read data held", 32'(rsp_rdata), 32'(mem_byte(a[17:0])));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && mem_rd_n && mem_wr_n && !rsp_done && !mem_oe, "R1 reset controls",
        {27'd0, req_ready, mem_rd_n, mem_wr_n, rsp_done, mem_oe}, 32'h1C);
    chk(mem_addr == '0, "R1 reset address", 32'(mem_addr), 0);
    chk(mem_attr == 4'hF, "R1 reset attr", 32'(mem_attr), 32'hF);
    for (int m = 0; m < 3; m++) begin
      logic [3:0]  mode = (m == 0) ? 4'b0101 : (m == 1) ? 4'hF : 4'h0;
      logic [11:0] base = 12'(m * 32'h29B + 32'h123);
      for (int ws = 0; ws <= 20; ws++) begin
        for (int wr = 0; wr < 2; wr++) begin
          run_access(wr[0], 22'(ws * 32'h2F1B3 + wr * 32'h15A5A + m * 32'h3C3C7 + 32'h0A5F1),
                     8'(ws * 37 + wr * 91 + m * 13), ws, mode, base);
        end
      end
      for (int sel = 0; sel < 8; sel++) begin
        run_access(sel[0], {4'(sel + m), 3'(sel), 15'(sel * 1234 + m)},
                   8'(sel * 29 + 7), (sel % 3) + 1, mode, base);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule